// File: doc/BRIEF.md
# Fixed-Point Overflow Trap Unit

This block sits beside the integer datapath and turns the status of a finished fixed-point operation into three decisions. It gives the next 4-bit condition code and says whether the destination registers may be written. It also says whether control must divert to the overflow trap vector instead of going on to the next instruction. The datapath gives an operation class, the overflow flag, the sign and zero status of the result and the adder carry-out. It also gives the condition code that is in force now and the fixed-point trap mask bit from the status word.

Two kinds of operation behave differently. A divide that overflows is abandoned: the register write is blocked and only the overflow flag of the condition code changes. Add, subtract, load-negate/absolute and modify operations always complete, even when they overflow. For these the condition code reports the sign of the wrapped result. Only add and subtract also report the carry. The unit registers every output. A decision appears one clock after the strobe that qualifies the inputs.

Top module: `fx_ovf_trap`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `cc_o`, `wr_en_o`, `trap_o`, `trap_vec_o` and `done_o` are all zero.
- R2: `done_o` is high exactly in the cycle after a cycle with `res_vld_i` high. When `done_o` is low, `wr_en_o` and `trap_o` are low and `cc_o` keeps its previous value.
- R3: Class encoding on `op_cls_i`: 0 = add/subtract, 1 = load negate/absolute, 2 = divide, 3 = modify-and-test. For classes 0, 1 and 3, `wr_en_o` is 1 whether or not `ovf_i` is set.
- R4: For classes 0, 1 and 3, `cc_o[2]` (flag 2) equals `ovf_i`. `cc_o[1:0]` (flags 3 and 4) is 00 when `zero_i` is set, otherwise 10 when `neg_i` is set, otherwise 01.
- R5: `cc_o[3]` (flag 1) equals `carry_i` for class 0. For classes 1 and 3 it equals `cc_i[3]`.
- R6: For class 2 with `ovf_i` set, `wr_en_o` is 0, `cc_o[2]` is 1, and `cc_o[3]`, `cc_o[1:0]` equal `cc_i[3]`, `cc_i[1:0]`.
- R7: For class 2 with `ovf_i` clear, `wr_en_o` is 1, `cc_o[2]` is 0, and the other flags equal those of `cc_i`.
- R8: `trap_o` is 1 exactly when `ovf_i` and `mask_i` were both set with the strobe. In that cycle `trap_vec_o` is 0x43; in every other cycle it is 0.
- R9: With `mask_i` at 0 an overflow raises no trap, but `cc_o` and `wr_en_o` follow R3 to R7 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_vld_i | input | 1 | Strobe qualifying the result status inputs |
| op_cls_i | input | 2 | Operation class (see R3) |
| ovf_i | input | 1 | Arithmetic overflow detected |
| neg_i | input | 1 | Result sign bit |
| zero_i | input | 1 | Result is zero |
| carry_i | input | 1 | Carry out of the adder's top bit |
| cc_i | input | 4 | Current condition code, bit 3 = flag 1 |
| mask_i | input | 1 | Fixed-point trap mask from the status word |
| cc_o | output | 4 | Next condition code |
| wr_en_o | output | 1 | Commit the register write |
| trap_o | output | 1 | Trap request |
| trap_vec_o | output | 8 | Trap vector address |
| done_o | output | 1 | Outputs carry a fresh decision |

## Verification
Each output register is reloaded on every strobe, so a wrong held condition code shows up on `cc_o` in the very next idle cycle. A wrong decision shows up in the cycle after its strobe. The risky paths are the divide-overflow freeze of flags 1, 3 and 4 and the class-dependent source of flag 1. A swapped source appears at once on `cc_o` when `carry_i` or `cc_i[3]` is chosen to differ. A lost write block or an unmasked trap shows up on `wr_en_o` or `trap_o` in the cycle after a divide with overflow, or after an overflow with the mask at 0.

// File: rtl/fx_ovf_pkg.sv
package fx_ovf_pkg;
  localparam int CC_W  = 4;
  localparam int CLS_W = 2;

  typedef enum logic [CLS_W-1:0] {
    CLS_ADDSUB = 2'd0,
    CLS_LOADNG = 2'd1,
    CLS_DIVIDE = 2'd2,
    CLS_MODIFY = 2'd3
  } op_cls_e;

  typedef struct packed {
    logic [CC_W-1:0] cc;
    logic            wr_en;
    logic            trap;
  } decision_t;
endpackage

// File: rtl/fx_sign_code.sv
module fx_sign_code (
  input  logic       neg_i,
  input  logic       zero_i,
  output logic [1:0] code_o
);
  always_comb begin
    if (zero_i)     code_o = 2'b00;
    else if (neg_i) code_o = 2'b10;
    else            code_o = 2'b01;
  end
endmodule

// File: rtl/fx_ovf_decide.sv
module fx_ovf_decide
  import fx_ovf_pkg::*;
(
  input  op_cls_e         cls_i,
  input  logic            ovf_i,
  input  logic            carry_i,
  input  logic [1:0]      code_i,
  input  logic [CC_W-1:0] cc_i,
  input  logic            mask_i,
  output decision_t       dec_o
);
  always_comb begin
    dec_o.trap = ovf_i & mask_i;
    unique case (cls_i)
      CLS_DIVIDE: begin
        dec_o.wr_en = ~ovf_i;
        dec_o.cc    = {cc_i[3], ovf_i, cc_i[1:0]};
      end
      CLS_ADDSUB: begin
        dec_o.wr_en = 1'b1;
        dec_o.cc    = {carry_i, ovf_i, code_i};
      end
      default: begin
        dec_o.wr_en = 1'b1;
        dec_o.cc    = {cc_i[3], ovf_i, code_i};
      end
    endcase
  end
endmodule

// File: rtl/fx_ovf_trap.sv
module fx_ovf_trap
  import fx_ovf_pkg::*;
#(
  parameter int          VEC_W    = 8,
  parameter logic [7:0]  TRAP_VEC = 8'h43
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             res_vld_i,
  input  logic [CLS_W-1:0] op_cls_i,
  input  logic             ovf_i,
  input  logic             neg_i,
  input  logic             zero_i,
  input  logic             carry_i,
  input  logic [CC_W-1:0]  cc_i,
  input  logic             mask_i,
  output logic [CC_W-1:0]  cc_o,
  output logic             wr_en_o,
  output logic             trap_o,
  output logic [VEC_W-1:0] trap_vec_o,
  output logic             done_o
);
  localparam logic [VEC_W-1:0] VEC = VEC_W'(TRAP_VEC);

  logic [1:0] code;
  decision_t  dec;

  fx_sign_code u_code (
    .neg_i  (neg_i),
    .zero_i (zero_i),
    .code_o (code)
  );

  fx_ovf_decide u_dec (
    .cls_i   (op_cls_e'(op_cls_i)),
    .ovf_i   (ovf_i),
    .carry_i (carry_i),
    .code_i  (code),
    .cc_i    (cc_i),
    .mask_i  (mask_i),
    .dec_o   (dec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cc_o       <= '0;
      wr_en_o    <= 1'b0;
      trap_o     <= 1'b0;
      trap_vec_o <= '0;
      done_o     <= 1'b0;
    end else begin
      done_o     <= res_vld_i;
      wr_en_o    <= res_vld_i & dec.wr_en;
      trap_o     <= res_vld_i & dec.trap;
      trap_vec_o <= (res_vld_i & dec.trap) ? VEC : '0;
      if (res_vld_i) cc_o <= dec.cc;
    end
  end

  // R2: idle cycles keep the condition code and drop the pulses
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> (!wr_en_o && !trap_o && (!$past(rst) -> $stable(cc_o))));

  // R3: non-divide classes always commit
  assert_commit_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(res_vld_i) && $past(op_cls_i) != CLS_DIVIDE) |-> wr_en_o);

  // R6: divide overflow freezes flags and blocks the write
  assert_div_freeze_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(res_vld_i) && $past(ovf_i) && $past(op_cls_i) == CLS_DIVIDE)
      |-> (!wr_en_o && cc_o[2] && cc_o[3] == $past(cc_i[3]) && cc_o[1:0] == $past(cc_i[1:0])));

  // R8: a trap needs an overflow under the mask, and carries the vector
  assert_trap_cause_R8: assert property (@(posedge clk) disable iff (rst)
    trap_o |-> ($past(res_vld_i) && $past(ovf_i) && $past(mask_i) && trap_vec_o == VEC));

  // R4: flags 3 and 4 never show the unused pattern after a completing operation
  assert_sign_code_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && done_o && $past(op_cls_i) != CLS_DIVIDE) |-> cc_o[1:0] != 2'b11);
endmodule

// File: tb/fx_ovf_trap_tb.sv
`timescale 1ns/1ps
module fx_ovf_trap_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       res_vld_i = 1'b0;
  logic [1:0] op_cls_i = '0;
  logic       ovf_i = 1'b0, neg_i = 1'b0, zero_i = 1'b0, carry_i = 1'b0, mask_i = 1'b0;
  logic [3:0] cc_i = '0;
  logic [3:0] cc_o;
  logic       wr_en_o, trap_o, done_o;
  logic [7:0] trap_vec_o;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  logic [3:0] e_cc = '0;
  logic       e_we = 0, e_trap = 0, e_done = 0;
  logic [7:0] e_vec = '0;
  string      tag = "R1";

  always #2 clk = ~clk;

  fx_ovf_trap u_dut (
    .clk(clk), .rst(rst), .res_vld_i(res_vld_i), .op_cls_i(op_cls_i),
    .ovf_i(ovf_i), .neg_i(neg_i), .zero_i(zero_i), .carry_i(carry_i),
    .cc_i(cc_i), .mask_i(mask_i), .cc_o(cc_o), .wr_en_o(wr_en_o),
    .trap_o(trap_o), .trap_vec_o(trap_vec_o), .done_o(done_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk({tag, " cc"},   cc_o,       e_cc);
    chk({tag, " we"},   wr_en_o,    e_we);
    chk({tag, " trap"}, trap_o,     e_trap);
    chk({tag, " vec"},  trap_vec_o, e_vec);
    chk({tag, " done"}, done_o,     e_done);
  endtask

  // behavioural expectation for the cycle after this strobe
  task automatic model(input bit v);
    int flag1, flag2, low;
    e_done = v;
    if (!v) begin
      e_we = 0; e_trap = 0; e_vec = 0;
      tag = "R2";
      return;
    end
    if (zero_i) low = 0; else if (neg_i) low = 2; else low = 1;
    if (op_cls_i == 2) begin
      e_we = !ovf_i;
      flag1 = cc_i[3];
      low = cc_i[1:0];
      tag = ovf_i ? "R6" : "R7";
    end else begin
      e_we = 1;
      flag1 = (op_cls_i == 0) ? carry_i : cc_i[3];
      tag = (op_cls_i == 0) ? "R5" : "R4";
    end
    flag2 = ovf_i;
    e_cc = 4'((flag1 << 3) | (flag2 << 2) | low);
    e_trap = ovf_i && mask_i;
    e_vec = e_trap ? 8'h43 : 8'h00;
    if (ovf_i) tag = mask_i ? "R8" : "R9";
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1";
    compare_all();
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    compare_all();
    for (int c = 0; c < 4; c++)
      for (int o = 0; o < 2; o++)
        for (int m = 0; m < 2; m++)
          for (int s = 0; s < 3; s++)
            for (int k = 0; k < 2; k++) begin
              for (int ph = 0; ph < 2; ph++) begin
                res_vld_i = (ph == 0);
                op_cls_i = 2'(c); ovf_i = o[0]; mask_i = m[0];
                zero_i = (s == 0); neg_i = (s != 1);
                carry_i = k[0];
                cc_i = 4'((c * 5 + o * 3 + s + k * 7 + m * 11) % 16);
                model(res_vld_i);
                @(negedge clk);
                compare_all();
              end
            end
    res_vld_i = 1'b0;
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule